// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token latches that two agents, a left port and a right port, use to claim shared resources. The latches are separate from any data memory. A port picks a latch with the low bits of its address while its semaphore select is high and its memory enable is low. It writes data bit 0 as 0 to ask for the token, or as 1 to give the token up or withdraw a waiting request. It then reads the latch to learn whether it holds the token.

Each latch is a five-state machine: `SEM_FREE`, `SEM_L_HELD`, `SEM_R_HELD`, `SEM_L_HELD_RWAIT` (left holds, right waits) and `SEM_R_HELD_LWAIT` (right holds, left waits).

The named transitions are:
- **grab**: free to held, on a request.
- **queue**: held to held-with-waiter, when the other side requests.
- **handoff**: held-with-waiter to held by the other side, when the owner releases.
- **drop**: held to free, when the owner releases and nobody waits.
- **withdraw**: held-with-waiter to held, when the waiter writes 1.
- **tie**: free to `SEM_L_HELD_RWAIT`, when both sides request in the same cycle.

Each port sees a mirrored view of the latch. The holder reads 0 and the other side reads 1. A free latch reads 1 from both sides.

Both port interfaces are synchronous to one clock. A read returns its value one cycle after the request, through a per-port output register.

Top module: `sem_bank`

## Requirements
- R1: The bank has NUM_SEM (8) latches, selected by address bits [2:0]. Address bits above bit 2 have no effect on a semaphore access.
- R2: On a write, only data bit 0 matters. A value of 0 is a request and a value of 1 is a release or a cancel. Data bits 8..1 have no effect.
- R3: A read returns all DATA_W bits equal to the port's view. The view is 0 when that port holds the latch and 1 otherwise, so a free latch reads all ones (9'h1FF) on both sides.
- R4: A request from the side that does not hold a latch leaves both views unchanged. It is recorded as a waiting request.
- R5: When the holder writes 1, a waiting other side becomes holder in that same state update. If nobody waits, the latch becomes free.
- R6: The read data appears in the cycle after the read request and stays there until the next read on that port. It reflects the latch state before any write applied in the request cycle, including a write from the other port.
- R7: An access happens only when semaphore select = 1 and memory enable = 0. With select = 0, writes have no effect.
- R8: After reset, every latch is free, both read outputs are all ones and both error outputs are 0.
- R9: When both sides request the same free latch in one cycle, the left side becomes holder and the right side's request is recorded as waiting.
- R10: An access with select = 1 and memory enable = 1 is ignored (no state change, no read capture). It raises that port's error output for exactly the following cycle.
- R11: A waiting side that writes 1 withdraws its request. A later release by the holder then frees the latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lt_sel | input | 1 | Left semaphore select |
| lt_mem_en | input | 1 | Left memory enable (must be 0 for an access) |
| lt_we | input | 1 | Left write (1) or read (0) |
| lt_addr | input | ADDR_W (16) | Left address, bits [2:0] pick the latch |
| lt_wdata | input | DATA_W (9) | Left write data, bit 0 used |
| lt_rdata | output | DATA_W (9) | Left registered read data |
| lt_err | output | 1 | Left disallowed-access pulse |
| rt_sel | input | 1 | Right semaphore select |
| rt_mem_en | input | 1 | Right memory enable (must be 0 for an access) |
| rt_we | input | 1 | Right write (1) or read (0) |
| rt_addr | input | ADDR_W (16) | Right address, bits [2:0] pick the latch |
| rt_wdata | input | DATA_W (9) | Right write data, bit 0 used |
| rt_rdata | output | DATA_W (9) | Right registered read data |
| rt_err | output | 1 | Right disallowed-access pulse |

## Verification
The latch assertions assume that each port issues at most one access per cycle, which the single-strobe port interface enforces. They also assume that requests and releases arrive as clean single-cycle strobes sampled at the clock edge. The stimulus drives every input half a period away from the active edge. It mixes reads, writes, disallowed selects and both-sides-same-latch cycles, so that ties, handoffs and withdrawals are all reached while each port still makes one operation per cycle. Upper address bits and upper data bits are driven with changing patterns so that their lack of effect is observed at the read outputs.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [2:0] {
        SEM_FREE,
        SEM_L_HELD,
        SEM_R_HELD,
        SEM_L_HELD_RWAIT,
        SEM_R_HELD_LWAIT
    } sem_state_e;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 9,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel,
    input  logic               mem_en,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NUM_SEM-1:0] req_vec,
    output logic [NUM_SEM-1:0] rel_vec,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               bad
);
    logic             ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        ok     = sel && !mem_en;
        bad    = sel && mem_en;
        idx    = addr[IDX_W-1:0];
        rd_idx = idx;
        rd_en  = ok && !we;
    end

    // one strobe per latch; only the addressed one can fire
    for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
        always_comb begin
            req_vec[g] = ok && we && (idx == IDX_W'(g)) && !wdata[0];
            rel_vec[g] = ok && we && (idx == IDX_W'(g)) &&  wdata[0];
        end
    end
endmodule

// File: rtl/sem_latch.sv
module sem_latch
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_view,
    output logic r_view
);
    sem_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEM_FREE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SEM_FREE: begin
                if (l_req)      nxt = r_req ? SEM_L_HELD_RWAIT : SEM_L_HELD;
                else if (r_req) nxt = SEM_R_HELD;
            end
            SEM_L_HELD: begin
                if (l_rel)      nxt = r_req ? SEM_R_HELD : SEM_FREE;
                else if (r_req) nxt = SEM_L_HELD_RWAIT;
            end
            SEM_R_HELD: begin
                if (r_rel)      nxt = l_req ? SEM_L_HELD : SEM_FREE;
                else if (l_req) nxt = SEM_R_HELD_LWAIT;
            end
            SEM_L_HELD_RWAIT: begin
                if (l_rel)      nxt = r_rel ? SEM_FREE : SEM_R_HELD;
                else if (r_rel) nxt = SEM_L_HELD;
            end
            SEM_R_HELD_LWAIT: begin
                if (r_rel)      nxt = l_rel ? SEM_FREE : SEM_L_HELD;
                else if (l_rel) nxt = SEM_R_HELD;
            end
            default: nxt = SEM_FREE;
        endcase
    end

    always_comb begin
        l_view = !((state == SEM_L_HELD) || (state == SEM_L_HELD_RWAIT));
        r_view = !((state == SEM_R_HELD) || (state == SEM_R_HELD_LWAIT));
    end

    assert_nonowner_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_view && !l_rel && r_req) |=> (!l_view && r_view));
    assert_handoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_L_HELD_RWAIT && l_rel && !r_rel) |=> (!r_view && l_view));
    assert_drop_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_R_HELD && r_rel && !l_req) |=> (l_view && r_view));
    assert_tie_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_FREE && l_req && r_req) |=> (state == SEM_L_HELD_RWAIT));
    assert_withdraw_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEM_R_HELD_LWAIT && l_rel && !r_rel) |=> (state == SEM_R_HELD));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
    parameter int DATA_W  = 9,
    parameter int NUM_SEM = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic [NUM_SEM-1:0] view_vec,
    input  logic               bad,
    output logic [DATA_W-1:0]  rdata,
    output logic               err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '1;
            err   <= 1'b0;
        end else begin
            err <= bad;
            if (rd_en) rdata <= {DATA_W{view_vec[rd_idx]}};
        end
    end

    assert_read_replicated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata == {DATA_W{rdata[0]}}));
    assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad |=> err);
    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |=> !err);
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 9,
    parameter int NUM_SEM = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lt_sel,
    input  logic              lt_mem_en,
    input  logic              lt_we,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic [DATA_W-1:0] lt_wdata,
    output logic [DATA_W-1:0] lt_rdata,
    output logic              lt_err,
    input  logic              rt_sel,
    input  logic              rt_mem_en,
    input  logic              rt_we,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata,
    output logic              rt_err
);
    localparam int IDX_W = $clog2(NUM_SEM);

    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel, l_view, r_view;
    logic               l_rd, r_rd, l_bad, r_bad;
    logic [IDX_W-1:0]   l_idx, r_idx;

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_l (
        .sel(lt_sel), .mem_en(lt_mem_en), .we(lt_we), .addr(lt_addr), .wdata(lt_wdata),
        .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd), .rd_idx(l_idx), .bad(l_bad));

    sem_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_dec_r (
        .sel(rt_sel), .mem_en(rt_mem_en), .we(rt_we), .addr(rt_addr), .wdata(rt_wdata),
        .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd), .rd_idx(r_idx), .bad(r_bad));

    for (genvar g = 0; g < NUM_SEM; g++) begin : g_latch
        sem_latch u_latch (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[g]), .l_rel(l_rel[g]), .r_req(r_req[g]), .r_rel(r_rel[g]),
            .l_view(l_view[g]), .r_view(r_view[g]));
    end

    sem_read_port #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_rd_l (
        .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .rd_idx(l_idx), .view_vec(l_view),
        .bad(l_bad), .rdata(lt_rdata), .err(lt_err));

    sem_read_port #(.DATA_W(DATA_W), .NUM_SEM(NUM_SEM)) u_rd_r (
        .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .rd_idx(r_idx), .view_vec(r_view),
        .bad(r_bad), .rdata(rt_rdata), .err(rt_err));

    // mirrored views can never both show ownership
    assert_views_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_view | r_view) == '1));
    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(l_req | l_rel) && $onehot0(r_req | r_rel));
endmodule

// File: tb/tb_sem_bank.sv
module tb_sem_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lt_sel = 0, lt_mem_en = 0, lt_we = 0;
    logic [15:0] lt_addr = '0;
    logic [8:0]  lt_wdata = '0;
    logic        rt_sel = 0, rt_mem_en = 0, rt_we = 0;
    logic [15:0] rt_addr = '0;
    logic [8:0]  rt_wdata = '0;
    logic [8:0]  lt_rdata, rt_rdata;
    logic        lt_err, rt_err;

    int n_chk = 0;
    int n_fail = 0;
    int owner [8];
    bit pend [8];
    logic [8:0] exp_lrd, exp_rrd;

    always #2.5 clk = ~clk;

    sem_bank dut (
        .clk(clk), .rst_n(rst_n),
        .lt_sel(lt_sel), .lt_mem_en(lt_mem_en), .lt_we(lt_we), .lt_addr(lt_addr),
        .lt_wdata(lt_wdata), .lt_rdata(lt_rdata), .lt_err(lt_err),
        .rt_sel(rt_sel), .rt_mem_en(rt_mem_en), .rt_we(rt_we), .rt_addr(rt_addr),
        .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_err(rt_err));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic setl(bit s, bit m, bit w, logic [15:0] a, logic [8:0] d);
        lt_sel = s; lt_mem_en = m; lt_we = w; lt_addr = a; lt_wdata = d;
    endtask

    task automatic setr(bit s, bit m, bit w, logic [15:0] a, logic [8:0] d);
        rt_sel = s; rt_mem_en = m; rt_we = w; rt_addr = a; rt_wdata = d;
    endtask

    task automatic idle();
        setl(0, 0, 0, '0, '0);
        setr(0, 0, 0, '0, '0);
    endtask

    // one clock with model update; checks outputs half a period after the edge
    task automatic tick(string tag);
        int la, ra;
        bit lok, rok, lq, lr, rq, rr;
        bit exp_lerr, exp_rerr;
        la = int'(lt_addr[2:0]);
        ra = int'(rt_addr[2:0]);
        lok = lt_sel && !lt_mem_en;
        rok = rt_sel && !rt_mem_en;
        exp_lerr = lt_sel && lt_mem_en;
        exp_rerr = rt_sel && rt_mem_en;
        if (lok && !lt_we) exp_lrd = {9{owner[la] != 1}};
        if (rok && !rt_we) exp_rrd = {9{owner[ra] != 2}};
        for (int i = 0; i < 8; i++) begin
            lq = lok && lt_we && la == i && !lt_wdata[0];
            lr = lok && lt_we && la == i &&  lt_wdata[0];
            rq = rok && rt_we && ra == i && !rt_wdata[0];
            rr = rok && rt_we && ra == i &&  rt_wdata[0];
            case (owner[i])
                0: if (lq) begin owner[i] = 1; pend[i] = rq; end
                   else if (rq) begin owner[i] = 2; pend[i] = 0; end
                1: if (lr) begin
                       owner[i] = ((pend[i] && !rr) || (!pend[i] && rq)) ? 2 : 0;
                       pend[i] = 0;
                   end else if (rq) pend[i] = 1;
                   else if (rr) pend[i] = 0;
                default: if (rr) begin
                       owner[i] = ((pend[i] && !lr) || (!pend[i] && lq)) ? 1 : 0;
                       pend[i] = 0;
                   end else if (lq) pend[i] = 1;
                   else if (lr) pend[i] = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check({tag, " left rdata"},  32'(lt_rdata), 32'(exp_lrd));
        check({tag, " right rdata"}, 32'(rt_rdata), 32'(exp_rrd));
        check("R10 left err",  32'(lt_err), 32'(exp_lerr));
        check("R10 right err", 32'(rt_err), 32'(exp_rerr));
    endtask

    task automatic rd_both(string tag, logic [15:0] la, logic [15:0] ra);
        setl(1, 0, 0, la, '0);
        setr(1, 0, 0, ra, '0);
        tick(tag);
        idle();
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] sl, sr;
        for (int i = 0; i < 8; i++) begin owner[i] = 0; pend[i] = 0; end
        exp_lrd = '1; exp_rrd = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check("R8 left rdata",  32'(lt_rdata), 32'h1FF);
        check("R8 right rdata", 32'(rt_rdata), 32'h1FF);
        check("R8 errs", 32'({lt_err, rt_err}), 32'h0);
        for (int i = 0; i < 8; i++) rd_both("R8 sweep", 16'(i), 16'(i));

        // R1 R2 R3: left grabs latch 5 via noisy upper address/data bits
        setl(1, 0, 1, 16'hA005, 9'h1FE); tick("R2 grab");
        rd_both("R1 view", 16'h0005, 16'h7FF5);
        check("R3 holder reads 0", 32'(lt_rdata), 32'h0);
        check("R3 other reads 1", 32'(rt_rdata), 32'h1FF);

        // R4: right requests held latch, views unchanged
        setr(1, 0, 1, 16'h0105, 9'h0F0); tick("R4 queue"); idle();
        rd_both("R4 view", 16'h0005, 16'h0005);
        check("R4 left still 0", 32'(lt_rdata), 32'h0);

        // R6: right reads while left releases in same cycle -> pre-state
        setl(1, 0, 1, 16'h0005, 9'h001);
        setr(1, 0, 0, 16'h0005, '0);
        tick("R6 same-cycle"); idle();
        check("R6 pre-write value", 32'(rt_rdata), 32'h1FF);
        // R5: handoff happened
        rd_both("R5 handoff", 16'h0005, 16'h0005);
        check("R5 right holds", 32'(rt_rdata), 32'h0);

        // R11: left waits then withdraws, right releases -> free
        setl(1, 0, 1, 16'h0005, 9'h000); tick("R11 queue");
        setl(1, 0, 1, 16'h0005, 9'h0FF); tick("R11 withdraw"); idle();
        setr(1, 0, 1, 16'h0005, 9'h001); tick("R11 release"); idle();
        rd_both("R11 free", 16'h0005, 16'h0005);
        check("R11 free left", 32'(lt_rdata), 32'h1FF);

        // R9: tie on latch 2
        setl(1, 0, 1, 16'h0002, 9'h000);
        setr(1, 0, 1, 16'h0002, 9'h000);
        tick("R9 tie"); idle();
        rd_both("R9 view", 16'h0002, 16'h0002);
        check("R9 left wins", 32'(lt_rdata), 32'h0);
        setl(1, 0, 1, 16'h0002, 9'h001); tick("R9 release"); idle();
        rd_both("R9 pending takes", 16'h0002, 16'h0002);
        check("R9 right owns", 32'(rt_rdata), 32'h0);

        // R10 and R7: disallowed and unselected writes ignored
        setl(1, 1, 1, 16'h0003, 9'h000); tick("R10 bad"); idle();
        setl(0, 0, 1, 16'h0003, 9'h000); tick("R7 unselected"); idle();
        rd_both("R7 R10 ignored", 16'h0003, 16'h0003);
        check("R10 latch free", 32'(lt_rdata), 32'h1FF);

        // near-exhaustive mixed sweep
        sl = 32'h1234_5678; sr = 32'h9ABC_DEF1;
        for (int n = 0; n < 4000; n++) begin
            sl ^= sl << 13; sl ^= sl >> 17; sl ^= sl << 5;
            sr ^= sr << 13; sr ^= sr >> 17; sr ^= sr << 5;
            setl(sl[0] | sl[1], sl[2] & sl[3] & sl[4], sl[5], sl[21:6], {sl[30:23], sl[22]});
            // bias right onto the left latch often to hit ties and handoffs
            setr(sr[0] | sr[1], sr[2] & sr[3] & sr[4], sr[5],
                 sr[6] ? {sr[21:9], sl[8:6]} : sr[21:6], {sr[30:23], sr[22]});
            tick("R3/R5/R6 sweep");
        end
        idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule